// File: doc/BRIEF.md
# Multi-Input Concentrating Output Queue

This block sits at one outlet of an unbuffered multistage cell fabric. The fabric has no internal storage, so a cell can reach its outlet from any of several stages. Each stage has its own line into the outlet interface. In one slot, every one of the `NUM_IN` lines may therefore carry a cell for this outlet. The outlet itself sends at most one cell per slot, so the cells queue up here.

A slot strobe marks each slot. On that strobe the block does three things:
- It concentrates the valid lines down to at most `NUM_PASS` cells, taking them in ascending line index.
- It writes those cells into a first-in first-out store of `DEPTH` cells in one step.
- It releases the oldest stored cell toward the outlet.

The release happens before the same slot's writes. A cell that arrives in a slot can therefore leave no earlier than the next slot. Cells dropped for lack of a concentrator output are counted in one saturating counter. Cells dropped for lack of queue space are counted in a second one. `NUM_PASS` and `DEPTH` are sized together to meet a cell-loss target.

Top module: `cellq_outport`

## Requirements
- R1: Cells taken in one slot enter the queue in ascending input-line index, and cells leave the queue in the order they entered it.
- R2: In one slot at most `NUM_PASS` cells pass the concentrator: the lowest-indexed valid lines. Every further valid line is dropped, and `conc_drop_o` rises by the number of such lines.
- R3: The queue never holds more than `DEPTH` cells. Passed cells that find no room are dropped, taking the highest-indexed ones first, and `ovf_drop_o` rises by their number.
- R4: `out_valid_o` is high for exactly the one clock cycle after a slot strobe edge at which the queue was not empty. It is then accompanied by the oldest cell on `out_data_o`, and it is low at all other times.
- R5: The readout comes before the insertions of the same slot. A full queue that receives cells therefore frees one place for them, and a cell written in slot t is not output before slot t+1.
- R6: When `slot_i` is low, `in_valid_i` and `in_data_i` have no effect on the queue, the outputs or the counters.
- R7: After reset the queue is empty, `out_valid_o` is low and both loss counters are zero.
- R8: Each loss counter saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_i | input | 1 | Slot strobe: one slot is processed on each edge where it is high |
| in_valid_i | input | NUM_IN | Per-line cell present flag; bit i is line i |
| in_data_i | input | NUM_IN*DATA_W | Line i cell at bits [i*DATA_W +: DATA_W] |
| out_valid_o | output | 1 | Cell released toward the outlet this cycle |
| out_data_o | output | DATA_W | Released cell |
| conc_drop_o | output | CNT_W | Saturating count of cells dropped at the concentrator |
| ovf_drop_o | output | CNT_W | Saturating count of cells dropped for a full queue |

## Verification
The bench hits the points where the concentrator and the queue meet:
- All lines valid at once. A concentrator that passed the wrong lines would reorder or lose the low-indexed cells.
- A full queue receiving several cells. A design that wrote before reading would lose one extra cell and raise the overflow count one too high.
- An empty queue receiving a cell. Forwarding that cell in the same slot would raise the output valid a slot early.
- Random line patterns with idle gaps carrying garbage inputs. A design that listened between strobes would move its counters or its queue.
- Long runs of full load. A counter that wrapped would show a small value where all-ones is expected.

// File: rtl/cellq_pkg.sv
package cellq_pkg;

  // smaller of two counts
  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // circular index step inside a store of mod entries
  function automatic int unsigned wrap_add(input int unsigned p, input int unsigned inc,
                                           input int unsigned mod);
    return (p + inc) % mod;
  endfunction

  // places left after the slot's readout
  function automatic int unsigned room_after_pop(input int unsigned depth,
                                                 input int unsigned occ,
                                                 input bit popped);
    return depth - occ + (popped ? 1 : 0);
  endfunction

endpackage

// File: rtl/cellq_concentrator.sv
module cellq_concentrator
  import cellq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_IN   = 6,
  parameter int NUM_PASS = 3,
  parameter int CIN_W    = $clog2(NUM_IN + 1)
) (
  input  logic [NUM_IN-1:0]          line_valid_i,
  input  logic [NUM_IN*DATA_W-1:0]   line_data_i,
  output logic [NUM_PASS*DATA_W-1:0] pass_data_o,
  output logic [CIN_W-1:0]           pass_cnt_o,
  output logic [CIN_W-1:0]           lost_cnt_o
);

  always_comb begin
    int unsigned rank;
    rank        = 0;
    pass_data_o = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (line_valid_i[i]) begin
        for (int j = 0; j < NUM_PASS; j++) begin
          if (rank == j) pass_data_o[j*DATA_W +: DATA_W] = line_data_i[i*DATA_W +: DATA_W];
        end
        rank = rank + 1;
      end
    end
    pass_cnt_o = CIN_W'(min_u(rank, NUM_PASS));
    lost_cnt_o = CIN_W'(rank - min_u(rank, NUM_PASS));
  end

endmodule

// File: rtl/cellq_mwfifo.sv
module cellq_mwfifo
  import cellq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_PASS = 3,
  parameter int DEPTH    = 8,
  parameter int CIN_W    = 3,
  parameter int OCC_W    = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_i,
  input  logic [NUM_PASS*DATA_W-1:0] push_data_i,
  input  logic [CIN_W-1:0]           push_cnt_i,
  output logic                       head_valid_o,
  output logic [DATA_W-1:0]          head_data_o,
  output logic [OCC_W-1:0]           occ_o,
  output logic                       pop_o,
  output logic [CIN_W-1:0]           ovf_cnt_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [OCC_W-1:0]  occ_q;
  logic [CIN_W-1:0]  take_n;

  always_comb begin
    int unsigned room;
    pop_o     = step_i && (occ_q != '0);
    room      = room_after_pop(DEPTH, occ_q, pop_o);
    take_n    = step_i ? CIN_W'(min_u(push_cnt_i, room)) : '0;
    ovf_cnt_o = step_i ? CIN_W'(push_cnt_i - take_n) : '0;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NUM_PASS; j++) begin
      if (j < take_n)
        store_q[wrap_add(wr_ptr_q, j, DEPTH)] <= push_data_i[j*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q     <= '0;
      wr_ptr_q     <= '0;
      occ_q        <= '0;
      head_valid_o <= 1'b0;
      head_data_o  <= '0;
    end else begin
      head_valid_o <= pop_o;
      if (pop_o) begin
        head_data_o <= store_q[rd_ptr_q];
        rd_ptr_q    <= PTR_W'(wrap_add(rd_ptr_q, 1, DEPTH));
      end
      if (step_i) begin
        wr_ptr_q <= PTR_W'(wrap_add(wr_ptr_q, take_n, DEPTH));
        occ_q    <= OCC_W'(occ_q - OCC_W'(pop_o) + OCC_W'(take_n));
      end
    end
  end

  assign occ_o = occ_q;

endmodule

// File: rtl/cellq_losscnt.sv
module cellq_losscnt #(
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W:0] sum;

  assign sum = {1'b0, count_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count_o <= '0;
    else if (sum[CNT_W]) count_o <= '1;
    else                 count_o <= sum[CNT_W-1:0];
  end

endmodule

// File: rtl/cellq_outport.sv
module cellq_outport #(
  parameter int DATA_W   = 16,
  parameter int NUM_IN   = 6,
  parameter int NUM_PASS = 3,
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_i,
  input  logic [NUM_IN-1:0]        in_valid_i,
  input  logic [NUM_IN*DATA_W-1:0] in_data_i,
  output logic                     out_valid_o,
  output logic [DATA_W-1:0]        out_data_o,
  output logic [CNT_W-1:0]         conc_drop_o,
  output logic [CNT_W-1:0]         ovf_drop_o
);

  localparam int CIN_W = $clog2(NUM_IN + 1);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [NUM_IN-1:0]          gated_valid;
  logic [NUM_PASS*DATA_W-1:0] pass_data;
  logic [CIN_W-1:0]           acc_cnt;
  logic [CIN_W-1:0]           conc_loss_n;
  logic [CIN_W-1:0]           ovf_loss_n;
  logic [OCC_W-1:0]           occupancy;
  logic                       slot_pop;
  logic [CIN_W-1:0]           loss_inc [2];
  logic [CNT_W-1:0]           loss_cnt [2];

  assign gated_valid = slot_i ? in_valid_i : '0;

  cellq_concentrator #(
    .DATA_W(DATA_W), .NUM_IN(NUM_IN), .NUM_PASS(NUM_PASS), .CIN_W(CIN_W)
  ) conc_i (
    .line_valid_i(gated_valid),
    .line_data_i (in_data_i),
    .pass_data_o (pass_data),
    .pass_cnt_o  (acc_cnt),
    .lost_cnt_o  (conc_loss_n)
  );

  cellq_mwfifo #(
    .DATA_W(DATA_W), .NUM_PASS(NUM_PASS), .DEPTH(DEPTH), .CIN_W(CIN_W), .OCC_W(OCC_W)
  ) fifo_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (slot_i),
    .push_data_i (pass_data),
    .push_cnt_i  (acc_cnt),
    .head_valid_o(out_valid_o),
    .head_data_o (out_data_o),
    .occ_o       (occupancy),
    .pop_o       (slot_pop),
    .ovf_cnt_o   (ovf_loss_n)
  );

  assign loss_inc[0] = conc_loss_n;
  assign loss_inc[1] = ovf_loss_n;

  for (genvar g = 0; g < 2; g++) begin : g_loss
    cellq_losscnt #(.CNT_W(CNT_W), .INC_W(CIN_W)) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (loss_inc[g]),
      .count_o(loss_cnt[g])
    );
  end

  assign conc_drop_o = loss_cnt[0];
  assign ovf_drop_o  = loss_cnt[1];

endmodule

// File: rtl/cellq_outport_chk.sv
module cellq_outport_chk #(
  parameter int NUM_IN   = 6,
  parameter int NUM_PASS = 3,
  parameter int DEPTH    = 8,
  parameter int CIN_W    = 3,
  parameter int OCC_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_i,
  input logic [NUM_IN-1:0] in_valid_i,
  input logic              out_valid_o,
  input logic [OCC_W-1:0]  occupancy,
  input logic              slot_pop,
  input logic [CIN_W-1:0]  acc_cnt,
  input logic [CIN_W-1:0]  conc_loss_n,
  input logic [CIN_W-1:0]  ovf_loss_n
);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH); // R3

  AST_CONC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc_cnt) <= NUM_PASS); // R2

  AST_CONC_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i |-> int'(acc_cnt) + int'(conc_loss_n) == $countones(in_valid_i)); // R2

  AST_OCC_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i |=> int'(occupancy) == int'($past(occupancy)) - int'($past(slot_pop))
                                  + int'($past(acc_cnt)) - int'($past(ovf_loss_n))); // R5

  AST_OUT_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> !out_valid_o); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> $stable(occupancy)); // R6

  AST_EMPTY_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && occupancy == '0) |=> !out_valid_o); // R5

endmodule

bind cellq_outport cellq_outport_chk #(
  .NUM_IN(NUM_IN), .NUM_PASS(NUM_PASS), .DEPTH(DEPTH), .CIN_W(CIN_W), .OCC_W(OCC_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_i     (slot_i),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .occupancy  (occupancy),
  .slot_pop   (slot_pop),
  .acc_cnt    (acc_cnt),
  .conc_loss_n(conc_loss_n),
  .ovf_loss_n (ovf_loss_n)
);

// File: tb/cellq_outport_tb.sv
module cellq_outport_tb_top;

  localparam int DW = 16;
  localparam int NI = 6;
  localparam int NP = 3;
  localparam int DP = 5;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             slot_i = 1'b0;
  logic [NI-1:0]    in_valid_i = '0;
  logic [NI*DW-1:0] in_data_i = '0;
  logic             out_valid_o;
  logic [DW-1:0]    out_data_o;
  logic [CW-1:0]    conc_drop_o;
  logic [CW-1:0]    ovf_drop_o;

  cellq_outport #(.DATA_W(DW), .NUM_IN(NI), .NUM_PASS(NP), .DEPTH(DP), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .conc_drop_o(conc_drop_o), .ovf_drop_o(ovf_drop_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int slot_no = 0;

  int unsigned mq[$];
  int m_conc = 0;
  int m_ovf  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one slot; entered and left at a negative edge
  task automatic do_slot(input logic [NI-1:0] mask, input string req);
    bit          exp_v;
    int unsigned exp_d;
    int          taken;
    exp_v = 0;
    exp_d = 0;
    slot_no++;
    slot_i     = 1'b1;
    in_valid_i = mask;
    for (int i = 0; i < NI; i++)
      in_data_i[i*DW +: DW] = DW'({slot_no[7:0], 8'(i)});
    // model: readout first (R5), then ascending insertion (R1, R2, R3)
    if (mq.size() > 0) begin
      exp_v = 1;
      exp_d = mq.pop_front();
    end
    taken = 0;
    for (int i = 0; i < NI; i++) begin
      if (mask[i]) begin
        if (taken < NP) begin
          taken++;
          if (mq.size() < DP) mq.push_back({slot_no[7:0], 8'(i)});
          else m_ovf = (m_ovf < CMAX) ? m_ovf + 1 : CMAX;
        end else begin
          m_conc = (m_conc < CMAX) ? m_conc + 1 : CMAX;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    slot_i = 1'b0;
    check(out_valid_o == exp_v, {req, " R4 valid"}, int'(out_valid_o), int'(exp_v));
    if (exp_v) check(out_data_o == DW'(exp_d), {req, " R1 order"}, int'(out_data_o), int'(exp_d));
    check(int'(conc_drop_o) == m_conc, {req, " R2 conc count"}, int'(conc_drop_o), m_conc);
    check(int'(ovf_drop_o) == m_ovf, {req, " R3 ovf count"}, int'(ovf_drop_o), m_ovf);
  endtask

  // cycles without a strobe carrying garbage on the lines (R6)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid_i = NI'($urandom);
      in_data_i  = {$urandom, $urandom, $urandom};
      @(posedge clk);
      @(negedge clk);
      check(!out_valid_o, "R6 idle valid", int'(out_valid_o), 0);
      check(int'(conc_drop_o) == m_conc && int'(ovf_drop_o) == m_ovf, "R6 idle counters",
            int'(conc_drop_o) + int'(ovf_drop_o), m_conc + m_ovf);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid_o, "R7 reset valid", int'(out_valid_o), 0);
    check(conc_drop_o == '0, "R7 reset conc", int'(conc_drop_o), 0);
    check(ovf_drop_o == '0, "R7 reset ovf", int'(ovf_drop_o), 0);
    do_slot('0, "R7 empty");
    // arrival into an empty queue is not forwarded in its own slot
    do_slot(6'b000100, "R5 first");
    do_slot('0, "R5 next");
    // all lines busy: three lowest pass, three lost
    do_slot(6'b111111, "R2 full load");
    do_slot(6'b101010, "R1 sparse");
    idle(3);
    // fill and overflow; readout frees a place for the arrivals
    do_slot(6'b111000, "R3 fill");
    do_slot(6'b010111, "R3 overflow");
    do_slot(6'b000011, "R5 full queue");
    for (int k = 0; k < 8; k++) do_slot('0, "R1 drain");
    // random patterns with random gaps
    for (int k = 0; k < 300; k++) begin
      do_slot(NI'($urandom), "R1 random");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 2));
    end
    // saturation of both counters under sustained full load
    for (int k = 0; k < 140; k++) do_slot(6'b111111, "R8 load");
    check(int'(conc_drop_o) == CMAX, "R8 conc saturate", int'(conc_drop_o), CMAX);
    check(int'(ovf_drop_o) == CMAX, "R8 ovf saturate", int'(ovf_drop_o), CMAX);
    finish_run();
  end

endmodule